// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block turns a raw "both alert tones present" flag from a tone detector into a clean, time-qualified, active-low steering output. It replaces the resistor-capacitor guard network normally hung on such a detector. Two digital run counters, advanced by a one-millisecond tick, stand in for the RC network. The present guard and the absent guard are set independently, so either one may be the longer.

A second stage measures each qualified alert. The measured length runs from the first raw-high tick of the qualifying run to the last raw-high tick before release. Short dropouts inside the alert count toward that length. When the steering output releases, the stage emits a one-cycle verdict strobe. The verdict is valid when the length lies within programmed minimum and maximum limits and no inner dropout was longer than the dropout limit. Otherwise it is invalid. A controller uses the steering edge and the verdict to decide whether to acknowledge a call-waiting or idle-state alert.

Top module: `alert_qualifier`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `steer_n` is 1, `guard_phase` is 0 and both strobes are 0.
- R2: With `steer_n` high, `steer_n` goes low on the clock edge that samples the `present_guard`-th consecutive tick with `raw_det` high. Ticks seen while `raw_det` is low do not count. A guard value of 0 acts as 1.
- R3: If `raw_det` goes low before the present guard expires, the present count restarts from zero.
- R4: With `steer_n` low, `steer_n` returns high on the edge that samples the `absent_guard`-th consecutive tick with `raw_det` low. If `raw_det` returns high before that, the absent count restarts and `steer_n` stays low.
- R5: The present and absent guard values act independently, and either may be the larger.
- R6: After a release, a new alert qualifies again under R2, with no extra delay.
- R7: On the edge where `steer_n` rises, exactly one of `valid_stb` and `invalid_stb` is high for one cycle, and never otherwise. `valid_stb` is chosen when the length L satisfies `min_len` <= L <= `max_len` and no inner dropout exceeded `max_dropout`. L counts the ticks from the first raw-high tick of the qualifying run to the last raw-high tick, with inner dropouts included.
- R8: A pulse with L below `min_len` gives `invalid_stb`. L equal to `min_len` is valid.
- R9: A pulse with L above `max_len` gives `invalid_stb`. L equal to `max_len` is valid.
- R10: An inner dropout is a run of consecutive raw-low ticks that ends with `raw_det` high while `steer_n` is low. A dropout longer than `max_dropout` ticks makes the verdict invalid. A dropout of exactly `max_dropout` ticks does not.
- R11: While `enable` is low, all counters clear and, from the next edge on, `steer_n` is 1 and `guard_phase` is 0. No strobe is emitted. After `enable` returns high, a full present guard is needed.
- R12: `guard_phase` encodes 0 = idle, 1 = counting present ticks (at least one counted), 2 = held with no absent tick counted, and 3 = held with at least one absent tick counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| raw_det | input | 1 | Raw dual-tone present flag, synchronous to `clk` |
| enable | input | 1 | Qualifier enable; low clears the block |
| present_guard | input | GUARD_W | Present guard, in ticks |
| absent_guard | input | GUARD_W | Absent guard, in ticks |
| max_dropout | input | GUARD_W | Longest allowed inner dropout, in ticks |
| min_len | input | DUR_W | Shortest valid alert, in ticks |
| max_len | input | DUR_W | Longest valid alert, in ticks |
| steer_n | output | 1 | Active-low qualified detection |
| guard_phase | output | 2 | Guard state, encoded as in R12 |
| valid_stb | output | 1 | One-cycle valid-alert strobe |
| invalid_stb | output | 1 | One-cycle invalid-alert strobe |

## Verification
The bench uses the default widths. It first runs with a present guard of 3 ticks, an absent guard of 5, limits of 10 and 16 ticks, and a dropout limit of 2. It then swaps to a present guard of 6 and an absent guard of 2, so both orderings of the guards are exercised. These small values put the exact length and dropout boundaries within a few dozen ticks. A tick every fourth clock makes each guard expiry land on a known edge. Enable is dropped once in the middle of a held alert to show that the block clears without emitting a verdict.

// File: rtl/alert_qual_pkg.sv
package alert_qual_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_ARMING    = 2'd1,
    PH_HELD      = 2'd2,
    PH_RELEASING = 2'd3
  } guard_phase_e;
endpackage

// File: rtl/aq_guard_timer.sv
module aq_guard_timer
  import alert_qual_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               tick,
  input  logic               raw,
  input  logic [GUARD_W-1:0] present_len,
  input  logic [GUARD_W-1:0] absent_len,
  output logic               held,
  output logic [GUARD_W-1:0] run_cnt,
  output logic               qualify_ev,
  output logic               release_ev,
  output guard_phase_e       phase
);
  logic               opposing;
  logic [GUARD_W-1:0] limit;
  logic [GUARD_W:0]   cnt_inc;
  logic               expire;

  // A tick counts only while raw disagrees with the held state
  assign opposing   = held ? ~raw : raw;
  assign limit      = held ? absent_len : present_len;
  assign cnt_inc    = {1'b0, run_cnt} + 1'b1;
  assign expire     = enable && opposing && tick && (cnt_inc >= {1'b0, limit});
  assign qualify_ev = expire && !held;
  assign release_ev = expire && held;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      held    <= 1'b0;
      run_cnt <= '0;
    end else begin
      if (expire) held <= ~held;
      if (!opposing || expire) run_cnt <= '0;
      else if (tick)           run_cnt <= cnt_inc[GUARD_W-1:0];
    end
  end

  always_comb begin
    if (held) phase = (run_cnt != '0) ? PH_RELEASING : PH_HELD;
    else      phase = (run_cnt != '0) ? PH_ARMING    : PH_IDLE;
  end
endmodule

// File: rtl/aq_pulse_judge.sv
module aq_pulse_judge #(
  parameter int GUARD_W = 8,
  parameter int DUR_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               tick,
  input  logic               raw,
  input  logic               held,
  input  logic [GUARD_W-1:0] run_cnt,
  input  logic               qualify_ev,
  input  logic               release_ev,
  input  logic [GUARD_W-1:0] present_len,
  input  logic [GUARD_W-1:0] absent_len,
  input  logic [GUARD_W-1:0] max_drop,
  input  logic [DUR_W-1:0]   min_len,
  input  logic [DUR_W-1:0]   max_len,
  output logic               valid_stb,
  output logic               invalid_stb
);
  logic [DUR_W-1:0] dur;
  logic [DUR_W-1:0] dur_inc;
  logic [DUR_W-1:0] tail;
  logic [DUR_W-1:0] pulse_len;
  logic             bad;
  logic             gap_over;
  logic             in_range;

  assign dur_inc   = (dur == '1) ? dur : dur + 1'b1;
  assign tail      = DUR_W'(absent_len);
  // Release tick included in dur_inc; drop the terminal absence
  assign pulse_len = (dur_inc > tail) ? dur_inc - tail : '0;
  assign in_range  = (pulse_len >= min_len) && (pulse_len <= max_len);
  // Inner dropout ends when raw returns while still held
  assign gap_over  = held && raw && (run_cnt > max_drop);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      dur         <= '0;
      bad         <= 1'b0;
      valid_stb   <= 1'b0;
      invalid_stb <= 1'b0;
    end else begin
      valid_stb   <= release_ev && !bad && in_range;
      invalid_stb <= release_ev && (bad || !in_range);
      if (qualify_ev) begin
        dur <= DUR_W'(present_len);
        bad <= 1'b0;
      end else begin
        if (held && tick) dur <= dur_inc;
        if (gap_over)     bad <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/alert_qualifier.sv
module alert_qualifier
  import alert_qual_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int DUR_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_ms,
  input  logic               raw_det,
  input  logic               enable,
  input  logic [GUARD_W-1:0] present_guard,
  input  logic [GUARD_W-1:0] absent_guard,
  input  logic [GUARD_W-1:0] max_dropout,
  input  logic [DUR_W-1:0]   min_len,
  input  logic [DUR_W-1:0]   max_len,
  output logic               steer_n,
  output logic [1:0]         guard_phase,
  output logic               valid_stb,
  output logic               invalid_stb
);
  logic               held;
  logic [GUARD_W-1:0] run_cnt;
  logic               qualify_ev;
  logic               release_ev;
  guard_phase_e       phase;

  aq_guard_timer #(.GUARD_W(GUARD_W)) u_timer (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick_ms), .raw(raw_det),
    .present_len(present_guard), .absent_len(absent_guard),
    .held(held), .run_cnt(run_cnt), .qualify_ev(qualify_ev),
    .release_ev(release_ev), .phase(phase)
  );

  aq_pulse_judge #(.GUARD_W(GUARD_W), .DUR_W(DUR_W)) u_judge (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick_ms), .raw(raw_det),
    .held(held), .run_cnt(run_cnt), .qualify_ev(qualify_ev),
    .release_ev(release_ev), .present_len(present_guard),
    .absent_len(absent_guard), .max_drop(max_dropout),
    .min_len(min_len), .max_len(max_len),
    .valid_stb(valid_stb), .invalid_stb(invalid_stb)
  );

  assign steer_n     = ~held;
  assign guard_phase = phase;
endmodule

// File: rtl/alert_qualifier_chk.sv
module alert_qualifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_ms,
  input logic       raw_det,
  input logic       enable,
  input logic       steer_n,
  input logic [1:0] guard_phase,
  input logic       valid_stb,
  input logic       invalid_stb
);
  assert_fall_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(steer_n) |-> $past(raw_det && tick_ms && enable));

  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_n) |-> $past(!enable || (!raw_det && tick_ms)));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(valid_stb && invalid_stb));

  assert_strobe_at_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_stb || invalid_stb) |-> $rose(steer_n));

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (steer_n && !valid_stb && !invalid_stb && guard_phase == 2'd0));
endmodule

bind alert_qualifier alert_qualifier_chk u_chk (
  .clk(clk), .rst(rst), .tick_ms(tick_ms), .raw_det(raw_det), .enable(enable),
  .steer_n(steer_n), .guard_phase(guard_phase),
  .valid_stb(valid_stb), .invalid_stb(invalid_stb)
);

// File: tb/tb_alert_qualifier.sv
module tb_alert_qualifier;
  localparam int GW = 8;
  localparam int DW = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, raw = 1'b0, en = 1'b1;
  int pg = 3, ag = 5, md = 2, mn = 10, mx = 16;
  logic steer_n, valid_stb, invalid_stb;
  logic [1:0] phase;

  alert_qualifier #(.GUARD_W(GW), .DUR_W(DW)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick), .raw_det(raw), .enable(en),
    .present_guard(GW'(pg)), .absent_guard(GW'(ag)), .max_dropout(GW'(md)),
    .min_len(DW'(mn)), .max_len(DW'(mx)),
    .steer_n(steer_n), .guard_phase(phase),
    .valid_stb(valid_stb), .invalid_stb(invalid_stb)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  typedef struct { bit ok; string req; } verdict_t;
  verdict_t exp_q[$];
  logic prev_steer = 1'b1;

  task automatic check(bit cond, string req, int act, int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // One tick period is four clocks; tick is high during the first
  task automatic step(bit lvl);
    @(negedge clk); raw = lvl; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic steps(bit lvl, int n);
    for (int i = 0; i < n; i++) step(lvl);
  endtask

  function automatic bit model_ok(int len, int drop);
    return (len >= mn) && (len <= mx) && (drop <= md);
  endfunction

  // Driver: raw high h1, low d, high h2, then released; verdict queued
  task automatic play(int h1, int d, int h2, string req);
    verdict_t v;
    int len;
    len = (d > 0) ? h1 + d + h2 : h1;
    v.ok = model_ok(len, d);
    v.req = req;
    exp_q.push_back(v);
    steps(1, h1);
    if (d > 0) begin
      steps(0, d);
      steps(1, h2);
    end
    steps(0, ag);
    check(steer_n == 1'b1, {req, " released"}, steer_n, 1);
    steps(0, 2);
  endtask

  // Monitor: pop and compare every strobe
  always @(negedge clk) begin
    if (!rst && (valid_stb || invalid_stb)) begin
      if (exp_q.size() == 0) begin
        check(0, "R7/R11 unexpected strobe", 1, 0);
      end else begin
        verdict_t e;
        e = exp_q.pop_front();
        check(valid_stb == e.ok && invalid_stb == !e.ok, e.req, valid_stb, e.ok);
        check(steer_n == 1'b1 && prev_steer == 1'b0, "R7 strobe on rise", steer_n, 1);
      end
    end
    prev_steer <= steer_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    verdict_t v;
    repeat (3) @(negedge clk);
    check(steer_n == 1 && phase == 0 && !valid_stb && !invalid_stb, "R1 in reset", steer_n, 1);
    rst = 1'b0;
    @(negedge clk);
    check(steer_n == 1 && phase == 0 && !valid_stb && !invalid_stb, "R1 after reset", phase, 0);

    // R2 / R12 timing; pulse later broken by a long dropout (R10, R4)
    v.ok = 0; v.req = "R10 long dropout invalid"; exp_q.push_back(v);
    steps(1, 2);
    check(steer_n == 1, "R2 not yet", steer_n, 1);
    check(phase == 1, "R12 arming", phase, 1);
    step(1);
    check(steer_n == 0, "R2 qualifies", steer_n, 0);
    check(phase == 2, "R12 held", phase, 2);
    steps(1, 9);
    steps(0, 4);
    check(steer_n == 0, "R4 holds before absent guard", steer_n, 0);
    check(phase == 3, "R12 releasing", phase, 3);
    step(1);
    check(steer_n == 0 && phase == 2, "R4 absent restart", phase, 2);
    steps(0, 5);
    check(steer_n == 1 && phase == 0, "R4 released", phase, 0);
    steps(0, 2);

    // R3 present restart
    v.ok = 1; v.req = "R3 pulse valid"; exp_q.push_back(v);
    steps(1, 2); step(0); steps(1, 2);
    check(steer_n == 1, "R3 restart", steer_n, 1);
    step(1);
    check(steer_n == 0, "R3 qualifies after restart", steer_n, 0);
    steps(1, 8);
    steps(0, 5);
    steps(0, 2);

    play(8, 2, 4, "R10 dropout at limit valid");
    play(9, 0, 0, "R8 short invalid");
    play(10, 0, 0, "R8 min edge valid");
    play(16, 0, 0, "R9 max edge valid");
    play(17, 0, 0, "R9 long invalid");
    play(5, 3, 5, "R10 dropout over limit invalid");

    // R5 asymmetric guards
    pg = 6; ag = 2;
    v.ok = 1; v.req = "R5 asymmetric valid"; exp_q.push_back(v);
    steps(1, 5);
    check(steer_n == 1, "R5 long present guard", steer_n, 1);
    step(1);
    check(steer_n == 0, "R5 qualifies at 6", steer_n, 0);
    steps(1, 6);
    step(0);
    check(steer_n == 0, "R5 short absent not yet", steer_n, 0);
    step(0);
    check(steer_n == 1, "R5 short absent release", steer_n, 1);
    play(12, 0, 0, "R6 re-arm valid");
    play(7, 1, 4, "R6 second re-arm valid");

    // R11 enable low mid-alert
    pg = 3; ag = 5;
    steps(1, 4);
    check(steer_n == 0, "R11 held before disable", steer_n, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(steer_n == 1 && phase == 0, "R11 cleared", steer_n, 1);
    steps(1, 3);
    check(steer_n == 1, "R11 ticks ignored while off", steer_n, 1);
    @(negedge clk); en = 1'b1;
    v.ok = 1; v.req = "R11 pulse after re-enable"; exp_q.push_back(v);
    steps(1, 2);
    check(steer_n == 1, "R11 full guard needed", steer_n, 1);
    step(1);
    check(steer_n == 0, "R11 requalified", steer_n, 0);
    steps(1, 9);
    steps(0, 5);
    steps(0, 2);

    check(exp_q.size() == 0, "R7 every verdict delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule